// File: doc/BRIEF.md
# Addressed Serial Delay-Setting Receiver

This block takes delay and mute settings from a microcontroller over three wires: a shift clock, a data line and a request line. Data is shifted in on each falling edge of the shift clock. A rising edge on the request line latches the most recent frame, but only when the frame's address field matches this device. One address bit comes from a strap pin, so two receivers can share the same wires. The outputs are a 4-bit delay code and a mute-mode bit. Both feed the delay-line and muting logic downstream.

A mode pin changes what the four shared pins mean. In serial mode they are the request, the shift clock, the data line and the address strap. In pin mode the same four pins give the delay code directly. In pin mode the serial frames are ignored and the latched settings stay as they are.

All four pins are asynchronous to the system clock. They pass through a two-flop synchronizer before any edge is detected. These are slow control lines with no data stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `dly_ctl_rx`

## Requirements
- R1: Each of the four shared pins is synchronized through two flops. An action triggered by a pin edge takes effect in the third system clock after the pin changes, and the outputs show it from then on.
- R2: In serial mode, the data pin (index 2) is shifted in on each falling edge of the shift-clock pin (index 1). A frame is 14 bits long, sent as the 4 address bits first and then 10 setting bits, most significant first.
- R3: A frame is accepted only when its address bits, in send order, are 0, 1, 0, S, where S is the synchronized level of the strap pin (index 3). On a mismatch the code and mute outputs are left unchanged.
- R4: On a rising edge of the request pin (index 0), the last 14 bits shifted in are checked. The first four setting bits become the delay code, most significant first, and the fifth becomes the mute-mode bit. Any bits shifted in before those 14 are discarded.
- R5: The last five setting bits have no effect on either output.
- R6: After reset, in serial mode, the delay code is 11 (binary 1011) and the mute-mode bit is 0.
- R7: In pin mode (mode pin high), the delay code is the synchronized pin vector, with pin 0 as the least significant bit, and the mute-mode bit reads 0. Serial activity in pin mode does not alter the latched settings, which reappear when serial mode returns.
- R8: With the strap pin high, a frame addressed 0,1,0,1 is accepted and a frame addressed 0,1,0,0 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_mode_i | input | 1 | 1 selects pin mode, 0 selects serial mode |
| ctl_pin_i | input | 4 | Shared pins: 0 request, 1 shift clock, 2 data, 3 strap (pin mode: delay code bits 0 to 3) |
| delay_code_o | output | 4 | Active delay code |
| mute_mode_o | output | 1 | Latched mute-mode bit (0 in pin mode) |

## Verification
Frames carrying different codes and mute bits show whether bit order and field placement are correct. Frames with bad address bits, sent with the strap pin both low and high, show whether the address match really depends on the strap. Two frames that differ only in the five trailing bits show whether those bits are ignored. A frame preceded by extra leading bits shows whether only the last fourteen count. A pin-mode phase with shift activity on the pins, followed by a return to serial mode, shows whether the latched settings survive.

// File: rtl/dly_rx_pkg.sv
package dly_rx_pkg;
  localparam int PIN_W   = 4;
  localparam int ID_W    = 4;
  localparam int CODE_W  = 4;
  localparam int DATA_W  = 10;
  localparam int FRAME_W = ID_W + DATA_W;

  localparam int PIN_REQ   = 0;
  localparam int PIN_SCK   = 1;
  localparam int PIN_DAT   = 2;
  localparam int PIN_STRAP = 3;

  // address bits in send order: first sent is the MSB of the field
  function automatic logic [ID_W-1:0] own_address(input logic strap);
    return {1'b0, 1'b1, 1'b0, strap};
  endfunction
endpackage

// File: rtl/dly_rx_sync.sv
module dly_rx_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q <= {stage_q[STAGES-2:0], async_i};
      prev_q  <= stage_q[STAGES-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign rise_o[b] =  sync_o[b] & ~prev_q[b];
    assign fall_o[b] = ~sync_o[b] &  prev_q[b];
  end
endmodule

// File: rtl/dly_rx_shifter.sv
module dly_rx_shifter
  import dly_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sr_q <= '0;
    else if (en_i && shift_i)  sr_q <= {sr_q[FRAME_W-2:0], bit_i};
  end

  assign frame_o = sr_q;

  // R2: the frame only moves on a qualified shift-clock falling edge
  a_r2_shift_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && shift_i) |=> $stable(sr_q));
endmodule

// File: rtl/dly_rx_latch.sv
module dly_rx_latch
  import dly_rx_pkg::*;
#(
  parameter logic [CODE_W-1:0] RESET_CODE = 4'd11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               req_rise_i,
  input  logic               strap_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               mute_o
);
  localparam int CODE_MSB = DATA_W - 1;
  localparam int MUTE_POS = DATA_W - 1 - CODE_W;

  logic [ID_W-1:0]   id_field;
  logic              id_match;
  logic [CODE_W-1:0] code_q;
  logic              mute_q;

  assign id_field = frame_i[FRAME_W-1 -: ID_W];
  assign id_match = (id_field == own_address(strap_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RESET_CODE;
      mute_q <= 1'b0;
    end else if (en_i && req_rise_i && id_match) begin
      code_q <= frame_i[CODE_MSB -: CODE_W];
      mute_q <= frame_i[MUTE_POS];
    end
  end

  assign code_o = code_q;
  assign mute_o = mute_q;

  // R3: settings change only after a request edge with a matching address
  a_r3_code_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> $past(req_rise_i && id_match));
  a_r3_mute_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_q != $past(mute_q)) |-> $past(req_rise_i && id_match));
  // R7: pin mode leaves the latched settings alone
  a_r7_hold_in_pin_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(code_q) && $stable(mute_q)));
endmodule

// File: rtl/dly_ctl_rx.sv
module dly_ctl_rx
  import dly_rx_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] RESET_CODE  = 4'd11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_mode_i,
  input  logic [PIN_W-1:0]  ctl_pin_i,
  output logic [CODE_W-1:0] delay_code_o,
  output logic              mute_mode_o
);
  logic [PIN_W-1:0]   pin_sync, pin_rise, pin_fall;
  logic [FRAME_W-1:0] frame;
  logic [CODE_W-1:0]  lat_code;
  logic               lat_mute;
  logic               serial_en;

  assign serial_en = ~pin_mode_i;

  dly_rx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ctl_pin_i),
    .sync_o  (pin_sync),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  dly_rx_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (serial_en),
    .shift_i (pin_fall[PIN_SCK]),
    .bit_i   (pin_sync[PIN_DAT]),
    .frame_o (frame)
  );

  dly_rx_latch #(.RESET_CODE(RESET_CODE)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (serial_en),
    .req_rise_i (pin_rise[PIN_REQ]),
    .strap_i    (pin_sync[PIN_STRAP]),
    .frame_i    (frame),
    .code_o     (lat_code),
    .mute_o     (lat_mute)
  );

  assign delay_code_o = pin_mode_i ? pin_sync[CODE_W-1:0] : lat_code;
  assign mute_mode_o  = pin_mode_i ? 1'b0 : lat_mute;
endmodule

// File: tb/dly_ctl_rx_bench.sv
module dly_ctl_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_mode = 1'b0;
  logic [3:0] pins = 4'b0010;
  logic [3:0] code_o;
  logic       mute_o;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string tag = "R6";

  // behavioural reference state
  logic [3:0]  q1, q2, q3;
  logic [13:0] msr;
  logic [3:0]  mcode;
  logic        mmute;

  always #5 clk = ~clk;

  dly_ctl_rx u_dly_ctl_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_mode_i   (pin_mode),
    .ctl_pin_i    (pins),
    .delay_code_o (code_o),
    .mute_mode_o  (mute_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 = '0; q2 = '0; q3 = '0; msr = '0; mcode = 4'd11; mmute = 1'b0;
    end else begin
      if (!pin_mode && q2[0] && !q3[0] && msr[13:10] == {1'b0, 1'b1, 1'b0, q2[3]}) begin
        mcode = msr[9:6];
        mmute = msr[5];
      end
      if (!pin_mode && q3[1] && !q2[1]) msr = {msr[12:0], q2[2]};
      q3 = q2; q2 = q1; q1 = pins;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] ec;
      logic       em;
      ec = pin_mode ? q2 : mcode;
      em = pin_mode ? 1'b0 : mmute;
      n_vec++;
      if (code_o !== ec || mute_o !== em) begin
        n_bad++;
        $display("FAIL %s R1 cycle compare: code=%0d mute=%0b expected code=%0d mute=%0b",
                 tag, code_o, mute_o, ec, em);
      end
    end
  end

  task automatic check_fixed(input string t, input logic [3:0] ec, input logic em);
    n_vec++;
    if (code_o !== ec || mute_o !== em) begin
      n_bad++;
      $display("FAIL %s fixed check: code=%0d mute=%0b expected code=%0d mute=%0b",
               t, code_o, mute_o, ec, em);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); pins[2] = b;
    repeat (3) @(negedge clk); pins[1] = 1'b0;
    repeat (4) @(negedge clk); pins[1] = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_req();
    @(negedge clk); pins[0] = 1'b1;
    repeat (5) @(negedge clk); pins[0] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_frame(input logic [3:0] id, input logic [3:0] c,
                            input logic m, input logic [4:0] junk);
    logic [13:0] f;
    f = {id, c, m, junk};
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
    pulse_req();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tag = "R6"; check_fixed("R6", 4'd11, 1'b0);

    tag = "R2"; send_frame(4'b0100, 4'd5, 1'b1, 5'b10101);
    check_fixed("R2/R4", 4'd5, 1'b1);
    tag = "R4"; send_frame(4'b0100, 4'd12, 1'b0, 5'b00110);
    check_fixed("R4", 4'd12, 1'b0);

    tag = "R3"; send_frame(4'b0101, 4'd3, 1'b1, 5'b0);
    check_fixed("R3", 4'd12, 1'b0);
    send_frame(4'b1100, 4'd7, 1'b1, 5'b0);
    check_fixed("R3", 4'd12, 1'b0);

    tag = "R8"; @(negedge clk); pins[3] = 1'b1; repeat (4) @(negedge clk);
    send_frame(4'b0101, 4'd14, 1'b1, 5'b0);
    check_fixed("R8", 4'd14, 1'b1);
    send_frame(4'b0100, 4'd2, 1'b0, 5'b0);
    check_fixed("R8", 4'd14, 1'b1);
    @(negedge clk); pins[3] = 1'b0; repeat (4) @(negedge clk);

    tag = "R5"; send_frame(4'b0100, 4'd9, 1'b1, 5'b11111);
    check_fixed("R5", 4'd9, 1'b1);
    send_frame(4'b0100, 4'd9, 1'b1, 5'b00000);
    check_fixed("R5", 4'd9, 1'b1);

    tag = "R4";
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    send_frame(4'b0100, 4'd6, 1'b0, 5'b01010);
    check_fixed("R4 leading bits", 4'd6, 1'b0);

    tag = "R1"; pulse_req();
    check_fixed("R1 repeat request", 4'd6, 1'b0);

    tag = "R7"; @(negedge clk); pin_mode = 1'b1;
    for (int v = 0; v < 16; v += 5) begin
      @(negedge clk); pins = v[3:0];
      repeat (3) @(negedge clk);
      check_fixed("R7", v[3:0], 1'b0);
    end
    @(negedge clk); pins = 4'b0010;
    send_frame(4'b0100, 4'd1, 1'b1, 5'b0);
    @(negedge clk); pin_mode = 1'b0;
    @(negedge clk);
    check_fixed("R7 settings kept", 4'd6, 1'b0);
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule